// File: doc/BRIEF.md
# Parallel Camera Video Receiver

This block takes the parallel output of a camera-style sensor: a data bus of up to 16 bits, a line-valid strobe and a frame-valid strobe, all sampled on the rising edge of the pixel clock. A bus word is a beat of a pixel only when both strobes are high. A two-bit format select tells the block how to read each beat. The choices are 14-bit raw samples, 8-bit gain-corrected samples, 16-bit luma/chroma words, and a double-clocked 8-bit luma/chroma stream. In the double-clocked stream each pixel takes two bus beats, and four beats carry one 4:2:2 pixel pair.

The block sends out one 16-bit pixel stream. It has a valid strobe, a start-of-frame flag on the first pixel of each frame and an end-of-line flag on the last pixel of each line. In double-clocked mode it rebuilds every pixel as {luma, chroma}. The blue-difference chroma goes with the first pixel of a pair and the red-difference chroma with the second, using either of two byte orders. Per-frame statistics are latched when frame-valid falls. The block counts frame-valid-low stretches of any length, such as calibration gaps, as normal idle time.

Top module: `pvid_rx`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, pix_valid_o, pix_sof_o, pix_eol_o, align_err_o, frame_done_o, line_pixels_o and frame_lines_o are all zero.
- R2: Format code 0 (raw): every beat gives one pixel whose value is bus bits 13:0, zero-extended to 16 bits.
- R3: Format code 1 (8-bit): every beat gives one pixel whose value is bus bits 7:0, zero-extended.
- R4: Format code 2 (16-bit luma/chroma): every beat gives one pixel equal to the whole 16-bit bus word. Luma is in bits 15:8 and chroma in bits 7:0.
- R5: Format code 3 with order 0: the byte order is luma0, Cb, luma1, Cr on bus bits 7:0. Each group of four beats gives the pixels {luma0, Cb} and then {luma1, Cr}, in that order.
- R6: Format code 3 with order 1: the byte order is Cb, luma0, Cr, luma1. Each group gives the same two pixels as in R5.
- R7: A bus word is ignored whenever line-valid or frame-valid is low. This includes a line-valid pulse sent outside a frame.
- R8: pix_sof_o is high on the first output pixel of each frame and on no other pixel.
- R9: pix_eol_o is high on the last output pixel of each line and on no other pixel. The cycle after an end-of-line pixel carries no valid pixel.
- R10: In format 3, a line that ends partway through a four-beat group drops the incomplete group without output and sets align_err_o. align_err_o stays set until reset.
- R11: After each falling edge of frame-valid, frame_done_o pulses for one cycle. At the same time line_pixels_o shows the pixel count of the frame's last line, and frame_lines_o shows the number of lines in the frame that produced at least one pixel.
- R12: A frame-valid-low gap of any length produces no pixels and no error, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Format select: 0 raw, 1 8-bit, 2 16-bit luma/chroma, 3 double-clocked |
| order_i | input | 1 | Byte order for format 3: 0 = Y,Cb,Y,Cr; 1 = Cb,Y,Cr,Y |
| line_valid_i | input | 1 | Line-valid strobe from the camera |
| frame_valid_i | input | 1 | Frame-valid strobe from the camera |
| bus_i | input | 16 | Camera data bus |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 16 | Output pixel value |
| pix_sof_o | output | 1 | First pixel of a frame |
| pix_eol_o | output | 1 | Last pixel of a line |
| align_err_o | output | 1 | Sticky incomplete-group flag |
| frame_done_o | output | 1 | One-cycle pulse when frame statistics update |
| line_pixels_o | output | 12 | Pixel count of the last line of the latest frame |
| frame_lines_o | output | 12 | Line count of the latest frame |

## Verification
The assertions assume the camera keeps line-valid low for at least two clocks between lines. They also assume frame-valid changes only while line-valid is low, and that the format and order inputs change only while frame-valid has been low for several cycles. The stimulus drives every frame with blanking of three clocks between lines and at least six idle clocks around each frame edge. Format and order are changed only in the idle time before a frame starts. Junk bus values are driven during blanking and during a stray line-valid pulse outside any frame, so the ignore rule is exercised while the assumptions still hold.

// File: rtl/pvid_pkg.sv
package pvid_pkg;
    typedef enum logic [1:0] {
        FMT_RAW14 = 2'd0,
        FMT_MONO8 = 2'd1,
        FMT_YC16  = 2'd2,
        FMT_DC8   = 2'd3
    } fmt_e;
endpackage

// File: rtl/pvid_capture.sv
// Registers the camera strobes and bus, then derives beat, line-end and frame events.
module pvid_capture #(
    parameter int BUS_W    = 16,
    parameter int FE_DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid_i,
    input  logic             frame_valid_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             beat_o,
    output logic [BUS_W-1:0] word_o,
    output logic             line_end_o,
    output logic             frame_start_o,
    output logic             frame_end_o
);
    typedef struct packed {
        logic                lv;
        logic                fv;
        logic                fv_prev;
        logic [BUS_W-1:0]    word;
        logic                beat_prev;
        logic                line_end;
        logic [FE_DELAY-1:0] fe_sr;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic beat_now;
    logic fv_fall;

    always_comb begin
        st_d          = st_q;
        beat_now      = st_q.lv & st_q.fv;
        fv_fall       = st_q.fv_prev & ~st_q.fv;
        st_d.lv       = line_valid_i;
        st_d.fv       = frame_valid_i;
        st_d.fv_prev  = st_q.fv;
        st_d.word     = bus_i;
        st_d.beat_prev = beat_now;
        st_d.line_end = st_q.beat_prev & ~beat_now;
        st_d.fe_sr    = {st_q.fe_sr[FE_DELAY-2:0], fv_fall};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_o        = st_q.lv & st_q.fv;
    assign word_o        = st_q.word;
    assign line_end_o    = st_q.line_end;
    assign frame_start_o = st_q.fv & ~st_q.fv_prev;
    assign frame_end_o   = st_q.fe_sr[FE_DELAY-1];
endmodule

// File: rtl/pvid_formatter.sv
// Turns bus beats into pixels per format; rebuilds double-clocked luma/chroma pairs.
module pvid_formatter
    import pvid_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int RAW_W = 14,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic             order_i,
    input  logic             beat_i,
    input  logic [BUS_W-1:0] word_i,
    input  logic             line_end_i,
    input  logic             frame_start_i,
    output logic             f_valid_o,
    output logic [BUS_W-1:0] f_data_o,
    output logic             f_sof_o,
    output logic             align_err_o
);
    localparam int GRP_BEATS = 4;
    localparam int IDX_W     = $clog2(GRP_BEATS);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
        logic              pend_valid;
        logic [BUS_W-1:0]  pend;
        logic              first;
        logic              err;
    } fmt_state_t;

    fmt_state_t st_d, st_q;
    fmt_e       fmt;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] y0, cb, y1, cr;
    logic              first_now;

    always_comb begin
        st_d      = st_q;
        fmt       = fmt_e'(fmt_i);
        cur_byte  = word_i[BYTE_W-1:0];
        y0        = order_i ? st_q.b1 : st_q.b0;
        cb        = order_i ? st_q.b0 : st_q.b1;
        y1        = order_i ? cur_byte : st_q.b2;
        cr        = order_i ? st_q.b2 : cur_byte;
        f_valid_o = 1'b0;
        f_data_o  = '0;
        first_now = st_q.first | frame_start_i;

        if (st_q.pend_valid) begin
            f_valid_o       = 1'b1;
            f_data_o        = st_q.pend;
            st_d.pend_valid = 1'b0;
        end

        if (frame_start_i) begin
            st_d.first = 1'b1;
            st_d.idx   = '0;
        end

        if (beat_i) begin
            unique case (fmt)
                FMT_RAW14: begin
                    f_valid_o = 1'b1;
                    f_data_o  = {{(BUS_W-RAW_W){1'b0}}, word_i[RAW_W-1:0]};
                end
                FMT_MONO8: begin
                    f_valid_o = 1'b1;
                    f_data_o  = {{(BUS_W-BYTE_W){1'b0}}, cur_byte};
                end
                FMT_YC16: begin
                    f_valid_o = 1'b1;
                    f_data_o  = word_i;
                end
                FMT_DC8: begin
                    st_d.idx = st_q.idx + 1'b1;
                    case (st_q.idx)
                        2'd0: st_d.b0 = cur_byte;
                        2'd1: st_d.b1 = cur_byte;
                        2'd2: st_d.b2 = cur_byte;
                        default: begin
                            f_valid_o       = 1'b1;
                            f_data_o        = {y0, cb};
                            st_d.pend       = {y1, cr};
                            st_d.pend_valid = 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        if (line_end_i) begin
            if (fmt == FMT_DC8 && st_q.idx != '0) st_d.err = 1'b1;
            st_d.idx = '0;
        end

        f_sof_o = f_valid_o & first_now;
        if (f_valid_o) st_d.first = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign align_err_o = st_q.err;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |=> align_err_o);
endmodule

// File: rtl/pvid_out_stage.sv
// Holds one pixel back so the last pixel of a line can carry the end-of-line flag.
module pvid_out_stage #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             f_valid_i,
    input  logic [BUS_W-1:0] f_data_i,
    input  logic             f_sof_i,
    input  logic             line_end_i,
    output logic             pix_valid_o,
    output logic [BUS_W-1:0] pix_data_o,
    output logic             pix_sof_o,
    output logic             pix_eol_o
);
    typedef struct packed {
        logic             hold_valid;
        logic [BUS_W-1:0] hold;
        logic             hold_sof;
        logic             valid;
        logic [BUS_W-1:0] data;
        logic             sof;
        logic             eol;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        st_d.sof   = 1'b0;
        st_d.eol   = 1'b0;
        if (f_valid_i) begin
            if (st_q.hold_valid) begin
                st_d.valid = 1'b1;
                st_d.data  = st_q.hold;
                st_d.sof   = st_q.hold_sof;
            end
            st_d.hold_valid = 1'b1;
            st_d.hold       = f_data_i;
            st_d.hold_sof   = f_sof_i;
        end else if (line_end_i && st_q.hold_valid) begin
            st_d.valid      = 1'b1;
            st_d.data       = st_q.hold;
            st_d.sof        = st_q.hold_sof;
            st_d.eol        = 1'b1;
            st_d.hold_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_valid_o = st_q.valid;
    assign pix_data_o  = st_q.data;
    assign pix_sof_o   = st_q.sof;
    assign pix_eol_o   = st_q.eol;

    assert_sof_with_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof_o |-> pix_valid_o);
    assert_eol_with_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol_o |-> pix_valid_o);
    assert_gap_after_eol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_eol_o |=> !pix_valid_o);
endmodule

// File: rtl/pvid_line_stats.sv
// Counts output pixels per line and lines per frame; latches them at frame end.
module pvid_line_stats #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid_i,
    input  logic             pix_eol_i,
    input  logic             frame_end_i,
    output logic             frame_done_o,
    output logic [CNT_W-1:0] line_pixels_o,
    output logic [CNT_W-1:0] frame_lines_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pix_cnt;
        logic [CNT_W-1:0] line_cnt;
        logic [CNT_W-1:0] last_len;
        logic [CNT_W-1:0] lp;
        logic [CNT_W-1:0] fl;
        logic             done;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (pix_valid_i) begin
            st_d.pix_cnt = st_q.pix_cnt + 1'b1;
            if (pix_eol_i) begin
                st_d.last_len = st_q.pix_cnt + 1'b1;
                st_d.pix_cnt  = '0;
                st_d.line_cnt = st_q.line_cnt + 1'b1;
            end
        end
        if (frame_end_i) begin
            st_d.lp       = st_d.last_len;
            st_d.fl       = st_d.line_cnt;
            st_d.line_cnt = '0;
            st_d.last_len = '0;
            st_d.done     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_done_o  = st_q.done;
    assign line_pixels_o = st_q.lp;
    assign frame_lines_o = st_q.fl;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);
endmodule

// File: rtl/pvid_rx.sv
module pvid_rx #(
    parameter int BUS_W = 16,
    parameter int RAW_W = 14,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic             order_i,
    input  logic             line_valid_i,
    input  logic             frame_valid_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             pix_valid_o,
    output logic [BUS_W-1:0] pix_data_o,
    output logic             pix_sof_o,
    output logic             pix_eol_o,
    output logic             align_err_o,
    output logic             frame_done_o,
    output logic [CNT_W-1:0] line_pixels_o,
    output logic [CNT_W-1:0] frame_lines_o
);
    localparam int FE_DELAY = 3;

    logic             beat, line_end, frame_start, frame_end;
    logic [BUS_W-1:0] word;
    logic             f_valid, f_sof;
    logic [BUS_W-1:0] f_data;

    pvid_capture #(.BUS_W(BUS_W), .FE_DELAY(FE_DELAY)) u_cap (
        .clk, .rst_n, .line_valid_i, .frame_valid_i, .bus_i,
        .beat_o(beat), .word_o(word), .line_end_o(line_end),
        .frame_start_o(frame_start), .frame_end_o(frame_end));

    pvid_formatter #(.BUS_W(BUS_W), .RAW_W(RAW_W)) u_fmt (
        .clk, .rst_n, .fmt_i, .order_i, .beat_i(beat), .word_i(word),
        .line_end_i(line_end), .frame_start_i(frame_start),
        .f_valid_o(f_valid), .f_data_o(f_data), .f_sof_o(f_sof),
        .align_err_o);

    pvid_out_stage #(.BUS_W(BUS_W)) u_out (
        .clk, .rst_n, .f_valid_i(f_valid), .f_data_i(f_data), .f_sof_i(f_sof),
        .line_end_i(line_end), .pix_valid_o, .pix_data_o, .pix_sof_o, .pix_eol_o);

    pvid_line_stats #(.CNT_W(CNT_W)) u_stats (
        .clk, .rst_n, .pix_valid_i(pix_valid_o), .pix_eol_i(pix_eol_o),
        .frame_end_i(frame_end), .frame_done_o, .line_pixels_o, .frame_lines_o);
endmodule

// File: tb/sim_pvid_rx.sv
module sim_pvid_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]  fmt;
    logic        order;
    logic        lv, fv;
    logic [15:0] bus;
    logic        pix_valid, pix_sof, pix_eol, align_err, frame_done;
    logic [15:0] pix_data;
    logic [11:0] line_pixels, frame_lines;

    pvid_rx u0 (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .order_i(order),
        .line_valid_i(lv), .frame_valid_i(fv), .bus_i(bus),
        .pix_valid_o(pix_valid), .pix_data_o(pix_data), .pix_sof_o(pix_sof),
        .pix_eol_o(pix_eol), .align_err_o(align_err), .frame_done_o(frame_done),
        .line_pixels_o(line_pixels), .frame_lines_o(frame_lines));

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] e_data [0:1023];
    bit          e_sof  [0:1023];
    bit          e_eol  [0:1023];
    string       e_req  [0:1023];
    int wr = 0, rd = 0;
    int exp_lp = 0, exp_fl = 0, done_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Output monitor: compares every pixel with the expected stream (R2..R9).
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (rd < wr)
                check({pix_sof, pix_eol, pix_data} == {e_sof[rd], e_eol[rd], e_data[rd]},
                      e_req[rd], "pixel {sof,eol,data}",
                      {pix_sof, pix_eol, pix_data}, {e_sof[rd], e_eol[rd], e_data[rd]});
            else
                check(1'b0, "R7", "unexpected pixel", pix_data, 0);
            rd++;
        end
        if (rst_n && frame_done) begin
            done_seen++;
            check(line_pixels == 12'(exp_lp), "R11", "line_pixels", line_pixels, exp_lp);
            check(frame_lines == 12'(exp_fl), "R11", "frame_lines", frame_lines, exp_fl);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    function automatic logic [15:0] pat(input int seed, input int l, input int b);
        return 16'((seed * 911) + (l * 4099) + (b * 613) + ((b * l) << 7));
    endfunction

    task automatic push(input logic [15:0] d, input bit s, input string req);
        e_data[wr] = d; e_sof[wr] = s; e_eol[wr] = 1'b0; e_req[wr] = req; wr++;
    endtask

    task automatic tick(); @(posedge clk); #1; endtask

    // Drives one frame; nb beats per line; computes expected pixels arithmetically.
    task automatic send_frame(input int md, input int ord, input int nl,
                              input int nb, input int seed, input string req);
        logic [7:0] bb [0:3];
        bit first = 1'b1;
        int line_px, lines_px = 0, last_px = 0, done0;
        done0 = done_seen;
        fmt = 2'(md); order = ord[0];
        repeat (6) tick();
        fv = 1'b1; bus = 16'hDEAD;
        repeat (3) tick();
        for (int l = 0; l < nl; l++) begin
            line_px = 0;
            lv = 1'b1;
            for (int b = 0; b < nb; b++) begin
                bus = pat(seed, l, b);
                case (md)
                    0: begin push({2'b00, bus[13:0]}, first, req); first = 0; line_px++; end
                    1: begin push({8'h00, bus[7:0]}, first, req); first = 0; line_px++; end
                    2: begin push(bus, first, req); first = 0; line_px++; end
                    default: begin
                        bb[b % 4] = bus[7:0];
                        if (b % 4 == 3) begin
                            if (ord == 0) begin
                                push({bb[0], bb[1]}, first, req);
                                push({bb[2], bb[3]}, 1'b0, req);
                            end else begin
                                push({bb[1], bb[0]}, first, req);
                                push({bb[3], bb[2]}, 1'b0, req);
                            end
                            first = 0; line_px += 2;
                        end
                    end
                endcase
                tick();
            end
            lv = 1'b0; bus = 16'hBEEF;
            if (line_px > 0) begin e_eol[wr-1] = 1'b1; lines_px++; last_px = line_px; end
            repeat (3) tick();
        end
        exp_lp = last_px; exp_fl = lines_px;
        fv = 1'b0;
        repeat (10) tick();
        check(rd == wr, req, "pixels delivered", rd, wr);
        check(done_seen == done0 + 1, "R11", "frame_done pulses", done_seen - done0, 1);
    endtask

    initial begin
        fmt = 2'd0; order = 1'b0; lv = 1'b0; fv = 1'b0; bus = 16'h0;
        repeat (3) tick();
        check({pix_valid, pix_sof, pix_eol, align_err, frame_done} == 5'b0, "R1",
              "outputs in reset", {pix_valid, pix_sof, pix_eol, align_err, frame_done}, 0);
        rst_n = 1'b1;
        tick();
        check({line_pixels, frame_lines} == 24'h0, "R1", "stats after reset",
              {line_pixels, frame_lines}, 0);

        // R7: stray line-valid with frame-valid low produces nothing
        lv = 1'b1;
        for (int b = 0; b < 5; b++) begin bus = 16'(b * 77); tick(); end
        lv = 1'b0; repeat (8) tick();
        check(rd == 0 && !pix_valid, "R7", "pixels from stray line", rd, 0);

        send_frame(0, 0, 3, 5, 1, "R2");
        send_frame(1, 0, 2, 4, 2, "R3");
        send_frame(2, 0, 3, 3, 3, "R4");
        send_frame(0, 0, 1, 1, 4, "R9");       // single-pixel line: sof and eol together
        send_frame(3, 0, 2, 8, 5, "R5");
        send_frame(3, 1, 3, 4, 6, "R6");
        send_frame(3, 1, 2, 12, 7, "R8");
        check(align_err == 1'b0, "R10", "no error on whole groups", align_err, 0);

        // R12: long calibration-style gap, then a normal frame
        repeat (3000) tick();
        check(rd == wr && align_err == 1'b0, "R12", "idle gap quiet", {rd == wr, align_err}, 2);
        send_frame(1, 0, 2, 6, 8, "R12");

        // R10: partial group at line end is dropped and flagged
        send_frame(3, 0, 1, 6, 9, "R10");
        check(align_err == 1'b1, "R10", "align_err set", align_err, 1);
        send_frame(3, 0, 1, 4, 10, "R10");
        check(align_err == 1'b1, "R10", "align_err sticky", align_err, 1);

        finish_run();
    end
endmodule